// File: doc/BRIEF.md
# DDR SDRAM Command Bus Monitor

This block sits beside a four-bank DDR SDRAM command bus and samples it once per clock. It turns the clock-enable history, chip select, the three strobe lines, the bank-select pair and A10 into one decoded command. It keeps its own view of which banks hold an open row and which row that is. On the same cycle it judges each command against the bank-state rules and the minimum spacings between commands. A broken rule shows up as a violation flag and a 4-bit reason code.

Typical use is as a passive protocol checker next to a memory controller, in simulation or in silicon debug logic. The block drives nothing onto the memory bus. A command that breaks a rule is reported and is then treated as never issued, so later checks rest only on the legal history. The timing limits are parameters counted in clock cycles. Their defaults suit a 7.5 ns clock.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: The decoded command is NOP (code 0) when chip select is high, when chip select is low with RAS, CAS and WE all high, and on any cycle whose previous-cycle clock enable was low. The clock-enable history register resets to high.
- R2: With chip select low and RAS, CAS, WE all low, the command is mode-register set (1). RAS and CAS low with WE high is auto refresh (2) when clock enable is high in both cycles, and self-refresh entry (3) when it falls. RAS low with CAS and WE high is activate (4).
- R3: CAS low with RAS high is a column access: WE high gives read (5) or read with auto precharge (7), WE low gives write (6) or write with auto precharge (8), with A10 high choosing the auto-precharge form. RAS and WE low with CAS high is precharge: single bank (9) when A10 is low, all banks (10) when A10 is high, ignoring the bank bits. WE low alone is burst stop (11).
- R4: The bank index output equals the bank-select pair, with bank bits 00, 01, 10, 11 meaning banks 0 to 3. A legal activate marks that bank open from the next cycle and stores the row address in bits [12*b+11:12*b] of the open-row output (12-bit rows).
- R5: A mode-register set, auto refresh or self-refresh entry while any bank is open is flagged with code 2. With all banks idle it is legal.
- R6: Any non-NOP command issued fewer than T_MRD cycles (default 2) after a legal mode-register set is flagged with code 1.
- R7: A read or write to an idle bank is flagged with code 3. An activate to an open bank is flagged with code 4.
- R8: An activate is flagged with code 5 if fewer than T_RC (9) cycles after the last activate of the same bank, with code 6 if fewer than T_RRD (2) cycles after any activate, and with code 7 if fewer than T_RP (3) cycles after that bank was precharged. The codes are checked in the order 4, 5, 6, 7.
- R9: A column access is flagged with code 8 if fewer than T_RCD (3) cycles after its bank's activate. A precharge of an open bank is flagged with code 9 if fewer than T_RAS (6) cycles after that activate. A precharge of an idle bank is legal and has no effect.
- R10: A precharge of an open bank is flagged with code 10 if fewer than BURST_CLK + T_WR cycles (2 + 2) have passed since a write to it. Code 9 takes priority over code 10.
- R11: A column access with auto precharge issued in cycle c closes the bank in cycle c+BURST_CLK (read) or c+BURST_CLK+T_WR (write). The bank reads idle from the following cycle, and the T_RP wait starts from the close cycle. A column access to a bank in that closing window is flagged with code 11.
- R12: A flagged command changes no bank state, stored row or timer. All-bank precharge closes every open bank that is not already closing, and is flagged with code 9 or 10 if any such bank fails the matching rule.
- R13: Synchronous active-low reset marks all banks idle and clears every spacing timer. A command in the first cycle after reset is checked against no earlier history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable of the current cycle |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank select |
| a10 | input | 1 | Auto-precharge / all-bank select bit |
| row_addr | input | ROW_W | Row address presented with an activate |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | BA_W | Bank index of the command |
| bank_active_o | output | 2**BA_W | One bit per bank, 1 when a row is open |
| open_rows_o | output | 2**BA_W*ROW_W | Stored row per bank, bank 0 in the low bits |
| viol_o | output | 1 | Rule violation on this cycle |
| viol_code_o | output | 4 | Violation reason, 0 when none |

## Verification
The bench builds the monitor with four banks and 12-bit rows. It uses row cycle 9, active-to-precharge 6, activate-to-column 3, precharge 3, activate-to-activate 2, mode-register gap 2, write recovery 2 and a burst of 2 clocks. With limits this small, every gap from one cycle up to one past each limit can be swept, so both sides of every spacing boundary are seen. All 32 combinations of chip select, the strobes and A10 can also be decoded in a few hundred cycles. The sweeps place the auto-precharge close point, the precharge wait and the row-cycle limit next to each other, so the priority order between their codes is exercised.

// File: rtl/ddr_mon_pkg.sv
`timescale 1ns/1ps
// Shared command and violation encodings for the DDR command monitor.
// Assumes: both encodings fit in four bits.
package ddr_mon_pkg;

    typedef enum logic [3:0] {
        CMD_NOP  = 4'd0,
        CMD_MRS  = 4'd1,
        CMD_REF  = 4'd2,
        CMD_SREF = 4'd3,
        CMD_ACT  = 4'd4,
        CMD_RD   = 4'd5,
        CMD_WR   = 4'd6,
        CMD_RDA  = 4'd7,
        CMD_WRA  = 4'd8,
        CMD_PRE  = 4'd9,
        CMD_PREA = 4'd10,
        CMD_BST  = 4'd11
    } cmd_e;

    typedef enum logic [3:0] {
        V_NONE      = 4'd0,
        V_MRD       = 4'd1,
        V_NOT_IDLE  = 4'd2,
        V_BANK_IDLE = 4'd3,
        V_BANK_OPEN = 4'd4,
        V_RC        = 4'd5,
        V_RRD       = 4'd6,
        V_RP        = 4'd7,
        V_RCD       = 4'd8,
        V_RAS       = 4'd9,
        V_WR        = 4'd10,
        V_AP_BUSY   = 4'd11
    } viol_e;

endpackage

// File: rtl/ddr_cmd_decode.sv
`timescale 1ns/1ps
// Pure combinational decode of one command-bus cycle.
// Assumes: cke_prev is the clock enable sampled on the previous edge;
// a low cke_prev means the device ignores the cycle.
module ddr_cmd_decode
    import ddr_mon_pkg::*;
(
    input  logic cke_prev,
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic a10,
    output cmd_e cmd
);

    // Map the strobe pattern to a command code.
    always_comb begin
        cmd = CMD_NOP;
        if (cke_prev && !cs_n) begin
            case ({ras_n, cas_n, we_n})
                3'b000:  cmd = CMD_MRS;
                3'b001:  cmd = cke ? CMD_REF : CMD_SREF;
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = a10 ? CMD_RDA : CMD_RD;
                3'b100:  cmd = a10 ? CMD_WRA : CMD_WR;
                3'b010:  cmd = a10 ? CMD_PREA : CMD_PRE;
                3'b110:  cmd = CMD_BST;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/ddr_gap_timer.sv
`timescale 1ns/1ps
// Countdown that stays busy for SPAN-1 cycles after a start pulse, so an
// event SPAN cycles after the start is the first one allowed.
// Assumes: SPAN >= 1; a start while busy restarts the window.
module ddr_gap_timer #(
    parameter int SPAN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int W = (SPAN > 1) ? $clog2(SPAN) : 1;

    logic [W-1:0] left;

    // Load on start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            left <= '0;
        else if (start)
            left <= W'(SPAN - 1);
        else if (left != '0)
            left <= left - 1'b1;
    end

    assign busy = (left != '0);

endmodule

// File: rtl/ddr_bank_slot.sv
`timescale 1ns/1ps
// State of one bank: open flag, stored row, auto-precharge countdown and
// the per-bank spacing timers.
// Assumes: the top only raises do_* strobes for commands that passed every
// check, so no two strobes conflict in one cycle.
module ddr_bank_slot #(
    parameter int ROW_W    = 12,
    parameter int T_RC     = 9,
    parameter int T_RAS    = 6,
    parameter int T_RCD    = 3,
    parameter int T_RP     = 3,
    parameter int WR_WIN   = 4,
    parameter int RD_CLOSE = 2,
    parameter int WR_CLOSE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_act,
    input  logic             do_pre,
    input  logic             do_rd,
    input  logic             do_wr,
    input  logic             auto_pre,
    input  logic [ROW_W-1:0] row_in,
    output logic             active_o,
    output logic             closing_o,
    output logic             rc_busy_o,
    output logic             ras_busy_o,
    output logic             rcd_busy_o,
    output logic             rp_busy_o,
    output logic             wr_busy_o,
    output logic [ROW_W-1:0] row_o
);

    localparam int CLOSE_MAX = (WR_CLOSE > RD_CLOSE) ? WR_CLOSE : RD_CLOSE;
    localparam int AW        = $clog2(CLOSE_MAX + 1);

    logic          open_q;
    logic          pend_q;
    logic [AW-1:0] ap_left;
    logic          ap_fire;

    assign ap_fire = pend_q && (ap_left == '0);

    // Open on activate, close on explicit or automatic precharge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            open_q <= 1'b0;
        else if (do_act)
            open_q <= 1'b1;
        else if (do_pre || ap_fire)
            open_q <= 1'b0;
    end

    // Auto-precharge countdown from the column access to the close cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            ap_left <= '0;
        end else if ((do_rd || do_wr) && auto_pre) begin
            pend_q  <= 1'b1;
            ap_left <= do_wr ? AW'(WR_CLOSE - 1) : AW'(RD_CLOSE - 1);
        end else if (ap_fire) begin
            pend_q  <= 1'b0;
        end else if (pend_q) begin
            ap_left <= ap_left - 1'b1;
        end
    end

    // Row latched by each legal activate.
    always_ff @(posedge clk) begin
        if (!rst_n)
            row_o <= '0;
        else if (do_act)
            row_o <= row_in;
    end

    ddr_gap_timer #(.SPAN(T_RC))   u_rc  (.clk(clk), .rst_n(rst_n), .start(do_act),             .busy(rc_busy_o));
    ddr_gap_timer #(.SPAN(T_RAS))  u_ras (.clk(clk), .rst_n(rst_n), .start(do_act),             .busy(ras_busy_o));
    ddr_gap_timer #(.SPAN(T_RCD))  u_rcd (.clk(clk), .rst_n(rst_n), .start(do_act),             .busy(rcd_busy_o));
    ddr_gap_timer #(.SPAN(T_RP))   u_rp  (.clk(clk), .rst_n(rst_n), .start(do_pre || ap_fire),  .busy(rp_busy_o));
    ddr_gap_timer #(.SPAN(WR_WIN)) u_wr  (.clk(clk), .rst_n(rst_n), .start(do_wr),              .busy(wr_busy_o));

    assign active_o  = open_q;
    assign closing_o = pend_q;

    AST_ACT_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n) do_act |-> !open_q);  // R7
    AST_COL_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n) (do_rd || do_wr) |-> (open_q && !pend_q && !rcd_busy_o));  // R9
    AST_PRE_AFTER_RAS: assert property (@(posedge clk) disable iff (!rst_n) do_pre |-> (!ras_busy_o && !wr_busy_o));  // R10
    AST_AP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n) ap_fire |=> !open_q);  // R11

endmodule

// File: rtl/ddr_cmd_monitor.sv
`timescale 1ns/1ps
// Top of the DDR command monitor: decodes each bus cycle, judges it against
// bank-state and spacing rules, and commits only legal commands to the
// per-bank state.
// Assumes: all timing parameters are in clock cycles and are >= 1;
// BURST_CLK is the number of clocks a data burst occupies.
module ddr_cmd_monitor
    import ddr_mon_pkg::*;
#(
    parameter int BA_W      = 2,
    parameter int ROW_W     = 12,
    parameter int T_RC      = 9,
    parameter int T_RAS     = 6,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RRD     = 2,
    parameter int T_MRD     = 2,
    parameter int T_WR      = 2,
    parameter int BURST_CLK = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cke,
    input  logic                          cs_n,
    input  logic                          ras_n,
    input  logic                          cas_n,
    input  logic                          we_n,
    input  logic [BA_W-1:0]               ba,
    input  logic                          a10,
    input  logic [ROW_W-1:0]              row_addr,
    output logic [3:0]                    cmd_o,
    output logic [BA_W-1:0]               bank_o,
    output logic [(1<<BA_W)-1:0]          bank_active_o,
    output logic [(1<<BA_W)*ROW_W-1:0]    open_rows_o,
    output logic                          viol_o,
    output logic [3:0]                    viol_code_o
);

    localparam int NB       = 1 << BA_W;
    localparam int WR_WIN   = BURST_CLK + T_WR;
    localparam int RD_CLOSE = BURST_CLK;
    localparam int WR_CLOSE = BURST_CLK + T_WR;

    logic    cke_q;
    cmd_e    cmd;
    viol_e   code;
    logic    legal;
    logic    rrd_busy;
    logic    mrd_busy;
    logic    is_col;
    logic    is_ap;
    logic [NB-1:0] act_v, closing_v, rc_v, ras_v, rcd_v, rp_v, wr_v;
    logic [NB-1:0] closable;
    logic [NB-1:0] sel_onehot;

    // Clock-enable history; resets high so the first cycle is decoded.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cke_q <= 1'b1;
        else
            cke_q <= cke;
    end

    ddr_cmd_decode u_dec (
        .cke_prev (cke_q),
        .cke      (cke),
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .a10      (a10),
        .cmd      (cmd)
    );

    assign is_col     = (cmd == CMD_RD) || (cmd == CMD_WR) || (cmd == CMD_RDA) || (cmd == CMD_WRA);
    assign is_ap      = (cmd == CMD_RDA) || (cmd == CMD_WRA);
    assign closable   = act_v & ~closing_v;
    assign sel_onehot = NB'(1) << ba;

    // Rule check: pick the first broken rule for this command.
    always_comb begin
        code = V_NONE;
        if (cmd != CMD_NOP && mrd_busy) begin
            code = V_MRD;
        end else begin
            case (cmd)
                CMD_MRS, CMD_REF, CMD_SREF: begin
                    if (|act_v) code = V_NOT_IDLE;
                end
                CMD_ACT: begin
                    if (act_v[ba])       code = V_BANK_OPEN;
                    else if (rc_v[ba])   code = V_RC;
                    else if (rrd_busy)   code = V_RRD;
                    else if (rp_v[ba])   code = V_RP;
                end
                CMD_RD, CMD_WR, CMD_RDA, CMD_WRA: begin
                    if (!act_v[ba])          code = V_BANK_IDLE;
                    else if (closing_v[ba])  code = V_AP_BUSY;
                    else if (rcd_v[ba])      code = V_RCD;
                end
                CMD_PRE: begin
                    if (closable[ba]) begin
                        if (ras_v[ba])     code = V_RAS;
                        else if (wr_v[ba]) code = V_WR;
                    end
                end
                CMD_PREA: begin
                    if (|(closable & ras_v))     code = V_RAS;
                    else if (|(closable & wr_v)) code = V_WR;
                end
                default: code = V_NONE;
            endcase
        end
    end

    assign legal = (code == V_NONE);

    ddr_gap_timer #(.SPAN(T_RRD)) u_rrd (.clk(clk), .rst_n(rst_n), .start(legal && cmd == CMD_ACT), .busy(rrd_busy));
    ddr_gap_timer #(.SPAN(T_MRD)) u_mrd (.clk(clk), .rst_n(rst_n), .start(legal && cmd == CMD_MRS), .busy(mrd_busy));

    // One state slot per bank; strobes only for committed commands.
    for (genvar gi = 0; gi < NB; gi++) begin : g_bank
        logic hit;
        assign hit = (ba == BA_W'(gi));

        ddr_bank_slot #(
            .ROW_W    (ROW_W),
            .T_RC     (T_RC),
            .T_RAS    (T_RAS),
            .T_RCD    (T_RCD),
            .T_RP     (T_RP),
            .WR_WIN   (WR_WIN),
            .RD_CLOSE (RD_CLOSE),
            .WR_CLOSE (WR_CLOSE)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .do_act     (legal && cmd == CMD_ACT && hit),
            .do_pre     (legal && closable[gi] && ((cmd == CMD_PRE && hit) || cmd == CMD_PREA)),
            .do_rd      (legal && hit && (cmd == CMD_RD || cmd == CMD_RDA)),
            .do_wr      (legal && hit && (cmd == CMD_WR || cmd == CMD_WRA)),
            .auto_pre   (is_ap),
            .row_in     (row_addr),
            .active_o   (act_v[gi]),
            .closing_o  (closing_v[gi]),
            .rc_busy_o  (rc_v[gi]),
            .ras_busy_o (ras_v[gi]),
            .rcd_busy_o (rcd_v[gi]),
            .rp_busy_o  (rp_v[gi]),
            .wr_busy_o  (wr_v[gi]),
            .row_o      (open_rows_o[gi*ROW_W +: ROW_W])
        );
    end

    assign cmd_o         = cmd;
    assign bank_o        = ba;
    assign bank_active_o = act_v;
    assign viol_o        = !legal;
    assign viol_code_o   = code;

    AST_CKE_LOW_IS_NOP: assert property (@(posedge clk) disable iff (!rst_n) !cke_q |-> (cmd_o == CMD_NOP));  // R1
    AST_IDLE_FOR_MODE: assert property (@(posedge clk) disable iff (!rst_n) ((cmd_o == CMD_MRS || cmd_o == CMD_REF || cmd_o == CMD_SREF) && !viol_o) |-> (bank_active_o == '0));  // R5
    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n) $past(cmd_o == CMD_ACT && !viol_o) |-> |(bank_active_o & $past(sel_onehot)));  // R4
    AST_COL_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n) (is_col && !viol_o) |-> |(bank_active_o & sel_onehot));  // R7
    if (T_MRD > 1) begin : g_mrd_chk
        AST_MRS_GAP: assert property (@(posedge clk) disable iff (!rst_n) ($past(cmd_o == CMD_MRS && !viol_o) && cmd_o != CMD_NOP) |-> (viol_code_o == V_MRD));  // R6
    end

endmodule

// File: tb/sim_ddr_cmd_monitor.sv
`timescale 1ns/1ps
module sim_ddr_cmd_monitor;

    localparam int BA_W = 2, ROW_W = 12, NB = 4;
    localparam int TRC = 9, TRAS = 6, TRCD = 3, TRP = 3, TRRD = 2, TMRD = 2, TWR = 2, BCLK = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
    logic [BA_W-1:0] ba = '0;
    logic [ROW_W-1:0] row_addr = '0;
    logic [3:0] cmd_o, viol_code_o;
    logic [BA_W-1:0] bank_o;
    logic [NB-1:0] bank_active_o;
    logic [NB*ROW_W-1:0] open_rows_o;
    logic viol_o;

    always #4 clk = ~clk;

    ddr_cmd_monitor #(
        .BA_W(BA_W), .ROW_W(ROW_W), .T_RC(TRC), .T_RAS(TRAS), .T_RCD(TRCD), .T_RP(TRP),
        .T_RRD(TRRD), .T_MRD(TMRD), .T_WR(TWR), .BURST_CLK(BCLK)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .a10(a10), .row_addr(row_addr), .cmd_o(cmd_o), .bank_o(bank_o),
        .bank_active_o(bank_active_o), .open_rows_o(open_rows_o), .viol_o(viol_o),
        .viol_code_o(viol_code_o)
    );

    int n_chk = 0, n_bad = 0;
    logic [3:0] g_cmd, g_code;
    logic g_viol;
    logic [BA_W-1:0] g_bank;
    logic [NB-1:0] g_act;
    logic [NB*ROW_W-1:0] g_rows;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_cmd(input bit ckp, input bit ck, input bit s, input bit r,
                                   input bit c, input bit w, input bit ap);
        if (!ckp || s) return 0;
        if (!r && !c && !w) return 1;
        if (!r && !c && w) return ck ? 2 : 3;
        if (!r && c && w) return 4;
        if (r && !c && w) return ap ? 7 : 5;
        if (r && !c && !w) return ap ? 8 : 6;
        if (!r && c && !w) return ap ? 10 : 9;
        if (r && c && !w) return 11;
        return 0;
    endfunction

    task automatic cyc(input bit k, input bit s, input bit r, input bit c, input bit w,
                       input int b, input bit ap, input int row);
        @(negedge clk);
        cke = k; cs_n = s; ras_n = r; cas_n = c; we_n = w;
        ba = BA_W'(b); a10 = ap; row_addr = ROW_W'(row);
        #2;
        g_cmd = cmd_o; g_code = viol_code_o; g_viol = viol_o; g_bank = bank_o;
        g_act = bank_active_o; g_rows = open_rows_o;
    endtask

    task automatic nop();                   cyc(1, 1, 1, 1, 1, 0, 0, 0);   endtask
    task automatic nops(input int n);       repeat (n) nop();              endtask
    task automatic act(input int b, input int row); cyc(1, 0, 0, 1, 1, b, 0, row); endtask
    task automatic rdc(input int b, input bit ap);  cyc(1, 0, 1, 0, 1, b, ap, 0);  endtask
    task automatic wrc(input int b, input bit ap);  cyc(1, 0, 1, 0, 0, b, ap, 0);  endtask
    task automatic pre(input int b);        cyc(1, 0, 0, 1, 0, b, 0, 0);   endtask
    task automatic prea(input int b);       cyc(1, 0, 0, 1, 0, b, 1, 0);   endtask
    task automatic mrs();                   cyc(1, 0, 0, 0, 0, 0, 0, 0);   endtask
    task automatic aref();                  cyc(1, 0, 0, 0, 1, 0, 0, 0);   endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cke = 1'b1; cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; a10 = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #1200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R13: reset state
        do_reset();
        nop();
        chk("R13 banks idle after reset", int'(g_act), 0);
        chk("R13 no violation after reset", int'(g_viol), 0);

        // R1 R2 R3 R4: full decode sweep with clock enable high
        for (int v = 0; v < 32; v++) begin
            cyc(1, v[4], v[3], v[2], v[1], v % 4, v[0], 0);
            chk($sformatf("R1 R2 R3 decode pattern %0d", v), int'(g_cmd),
                exp_cmd(1, 1, v[4], v[3], v[2], v[1], v[0]));
            chk($sformatf("R4 bank echo pattern %0d", v), int'(g_bank), v % 4);
        end

        // R2 self-refresh entry, R1 suspended cycles
        do_reset();
        cyc(0, 0, 0, 0, 1, 0, 0, 0);
        chk("R2 self refresh entry", int'(g_cmd), 3);
        cyc(0, 0, 0, 1, 1, 0, 0, 0);
        chk("R1 clock enable low ignored", int'(g_cmd), 0);
        cyc(1, 0, 0, 1, 1, 0, 0, 0);
        chk("R1 previous enable low ignored", int'(g_cmd), 0);
        cyc(1, 0, 0, 1, 1, 0, 0, 0);
        chk("R2 activate after wake", int'(g_cmd), 4);

        // R4: bank mapping and row storage
        do_reset();
        for (int b = 0; b < NB; b++) begin
            act(b, 'h100 + b * 17);
            chk($sformatf("R4 activate bank %0d legal", b), int'(g_code), 0);
            nop();
        end
        nop();
        chk("R4 all banks open", int'(g_act), 15);
        for (int b = 0; b < NB; b++)
            chk($sformatf("R4 row of bank %0d", b), int'(g_rows[b*ROW_W +: ROW_W]), 'h100 + b * 17);

        // R9: activate to column gap
        for (int k = 1; k <= TRCD + 1; k++) begin
            do_reset();
            act(0, 5); nops(k - 1); rdc(0, 0);
            chk($sformatf("R9 act->rd gap %0d", k), int'(g_code), (k < TRCD) ? 8 : 0);
        end

        // R9 R12: activate to precharge gap, state after
        for (int k = 1; k <= TRAS + 1; k++) begin
            do_reset();
            act(1, 3); nops(k - 1); pre(1);
            chk($sformatf("R9 act->pre gap %0d", k), int'(g_code), (k < TRAS) ? 9 : 0);
            nop();
            chk($sformatf("R12 bank1 after pre gap %0d", k), int'(g_act[1]), (k < TRAS) ? 1 : 0);
        end

        // R8 R11: same-bank activate after auto-precharge read
        for (int k = TRCD + 1; k <= TRC + 1; k++) begin
            int close_at;
            int e;
            close_at = TRCD + BCLK;
            e = (k <= close_at) ? 4 : ((k < TRC) ? 5 : 0);
            do_reset();
            act(2, 1); nops(TRCD - 1); rdc(2, 1); nops(k - TRCD - 1); act(2, 2);
            chk($sformatf("R8 same-bank act gap %0d", k), int'(g_code), e);
        end

        // R8: precharge to activate gap
        for (int j = 1; j <= TRP + 1; j++) begin
            do_reset();
            act(3, 1); nops(TRC - 2); pre(3); nops(j - 1); act(3, 2);
            chk($sformatf("R8 pre->act gap %0d", j), int'(g_code), (j < TRP) ? 7 : 0);
        end

        // R8: activate to activate on different banks
        for (int k = 1; k <= TRRD + 1; k++) begin
            do_reset();
            act(0, 1); nops(k - 1); act(1, 1);
            chk($sformatf("R8 cross-bank act gap %0d", k), int'(g_code), (k < TRRD) ? 6 : 0);
        end

        // R10: write recovery before precharge
        for (int k = 1; k <= BCLK + TWR + 1; k++) begin
            int e;
            e = (TRCD + k < TRAS) ? 9 : ((k < BCLK + TWR) ? 10 : 0);
            do_reset();
            act(0, 1); nops(TRCD - 1); wrc(0, 0); nops(k - 1); pre(0);
            chk($sformatf("R10 wr->pre gap %0d", k), int'(g_code), e);
        end

        // R6: mode-register spacing
        for (int k = 1; k <= TMRD + 1; k++) begin
            do_reset();
            mrs();
            chk("R6 mode set legal when idle", int'(g_code), 0);
            nops(k - 1); act(0, 1);
            chk($sformatf("R6 mrs->act gap %0d", k), int'(g_code), (k < TMRD) ? 1 : 0);
        end

        // R5: all-idle requirement
        do_reset();
        act(0, 1); nops(TMRD);
        mrs();
        chk("R5 mode set with open bank", int'(g_code), 2);
        aref();
        chk("R5 refresh with open bank", int'(g_code), 2);
        cyc(0, 0, 0, 0, 1, 0, 0, 0);
        chk("R5 self refresh with open bank", int'(g_code), 2);
        do_reset();
        aref();
        chk("R5 refresh when idle", int'(g_code), 0);

        // R7 R12: bank-state errors, state untouched
        do_reset();
        rdc(1, 0);
        chk("R7 read idle bank", int'(g_code), 3);
        wrc(1, 1);
        chk("R7 write idle bank", int'(g_code), 3);
        act(1, 7); nops(3); act(1, 9);
        chk("R7 activate open bank", int'(g_code), 4);
        nop();
        chk("R12 row kept after flagged activate", int'(g_rows[ROW_W +: ROW_W]), 7);

        // R11: write with auto precharge close timing and busy window
        do_reset();
        act(0, 4); nops(TRCD - 1); wrc(0, 1);
        chk("R11 write auto precharge legal", int'(g_code), 0);
        rdc(0, 0);
        chk("R11 column during close window", int'(g_code), 11);
        for (int t = 2; t <= BCLK + TWR + 2; t++) begin
            nop();
            chk($sformatf("R11 bank0 open at +%0d", t), int'(g_act[0]), (t <= BCLK + TWR) ? 1 : 0);
        end

        // R11: read with auto precharge close timing
        do_reset();
        act(1, 4); nops(TRCD - 1); rdc(1, 1);
        for (int t = 1; t <= BCLK + 2; t++) begin
            nop();
            chk($sformatf("R11 bank1 open at +%0d after read", t), int'(g_act[1]), (t <= BCLK) ? 1 : 0);
        end

        // R12 R3: all-bank precharge, early and late
        do_reset();
        act(0, 1); nop(); act(2, 1); nop();
        prea(1);
        chk("R12 early all-bank precharge", int'(g_code), 9);
        nop();
        chk("R12 banks kept after flagged all-bank", int'(g_act), 5);
        do_reset();
        act(0, 1); nop(); act(2, 1); nops(TRAS);
        prea(1);
        chk("R3 all-bank precharge legal", int'(g_code), 0);
        nop();
        chk("R12 all banks closed", int'(g_act), 0);

        // R13: reset clears timers
        do_reset();
        act(0, 1);
        do_reset();
        act(0, 2);
        chk("R13 activate right after reset", int'(g_code), 0);
        do_reset();
        mrs();
        do_reset();
        act(1, 2);
        chk("R13 mode gap cleared by reset", int'(g_code), 0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule